// File: doc/BRIEF.md
# SAR Conversion Controller with Bus-Decoded Start and Read

This block is the digital half of a 12-bit successive-approximation converter. A processor-style bus (enable, active-low select, read/convert, a format pin and a low address bit) starts conversions and reads results. On a start command the controller puts the external sample/hold into hold, clears the approximation register and then tests one bit per clock, most significant first. Each test drives a trial code to the external DAC and reads back an external comparator. A short-cycle mode tests only the upper 8 bits.

After the last bit is decided the result register is loaded and the sample/hold returns to sample mode. The busy output stays high for a set number of acquisition clocks after that. Reads are already allowed during this acquisition interval. Commands that arrive while a conversion is running are ignored. The result is presented either as one 12-bit word or as one of two bytes.

States: `ST_IDLE` (waiting), `ST_HOLD` (sample/hold placed in hold), `ST_CLEAR` (register cleared), `ST_TRIAL` (one bit decided per clock), `ST_ACQ` (acquisition delay). Transitions: `IDLE->HOLD` on a decoded start, `HOLD->CLEAR` and `CLEAR->TRIAL` unconditionally, `TRIAL->ACQ` when the last bit is decided, `ACQ->IDLE` when the delay counter expires.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A bus command is decoded only when `bus_ce`=1 and `bus_cs_n`=0. In every other case no conversion starts and `data_oe` stays 0.
- R2: With `bus_rd_cnv`=0, `addr_lo`=0 starts a 12-bit conversion and `addr_lo`=1 starts an 8-bit conversion. `busy` is 1 in the first cycle after the clock edge that samples the command.
- R3: `hold` rises together with `busy`. The approximation register is cleared one cycle later and the trials begin the cycle after that. `hold` is never 1 while `busy` is 0, and `dac_code` is 0 whenever `hold` is 0.
- R4: Trials run MSB first. A trial bit is kept when `cmp_above`=0 (trial code not above the input) and cleared when `cmp_above`=1. For an ideal comparator with integer input V, a 12-bit conversion gives a result equal to V.
- R5: An 8-bit conversion runs exactly 8 trials on bits 11..4 and leaves result bits 3..0 at 0, which gives V with its 4 low bits cleared.
- R6: `hold` falls in the cycle after the last trial. `busy` stays high for ACQ_CLKS more cycles. `busy` is high for exactly 2 + N + ACQ_CLKS cycles, where N is 12 or 8.
- R7: A start command received while `busy`=1 is ignored. It neither restarts nor changes the running conversion.
- R8: `data_oe` is 0 while `hold`=1, even when a read is decoded. A read decoded during the acquisition interval is served.
- R9: Read format with `bus_rd_cnv`=1: `fmt_wide`=1 gives `data_out`=result[11:0]. `fmt_wide`=0 with `addr_lo`=0 gives `data_out`={4'b0, result[11:4]}. `fmt_wide`=0 with `addr_lo`=1 gives `data_out`={4'b0, result[3:0], 4'b0}.
- R10: `data_oe` is 1 exactly when a read is decoded and `hold`=0. `data_out` is 0 whenever `data_oe` is 0.
- R11: The result register changes only at the end of a conversion, so a read during acquisition returns the conversion just completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ce | input | 1 | Chip enable, active high |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_cnv | input | 1 | 1 = read, 0 = start conversion |
| fmt_wide | input | 1 | 1 = 12-bit parallel read, 0 = byte read |
| addr_lo | input | 1 | Selects conversion length or read byte |
| cmp_above | input | 1 | Comparator: 1 when the trial code exceeds the held input |
| hold | output | 1 | Sample/hold control, 1 = hold |
| dac_code | output | 12 | Trial code for the external DAC |
| busy | output | 1 | Status, high from start until the end of acquisition |
| data_out | output | 12 | Read data |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with its default 12/8-bit widths and ACQ_CLKS=2, so the acquisition window differs from the default and the busy-length formula is actually checked against the parameter. An ideal comparator (trial code above input) lets every input step of 17 across the whole 12-bit range, plus both end codes, be converted in both lengths. Each result is read back in all three formats. The small delay keeps each conversion under 20 cycles, so the sweep also covers mid-conversion restart attempts, reads during acquisition and undecoded bus cycles.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_CLEAR = 3'd2,
        ST_TRIAL = 3'd3,
        ST_ACQ   = 3'd4
    } conv_state_t;

    typedef enum logic [1:0] {
        RD_WIDE = 2'd0,
        RD_HIGH = 2'd1,
        RD_LOW  = 2'd2
    } read_fmt_t;

endpackage

// File: rtl/sar_bus_decode.sv
module sar_bus_decode
    import sar_pkg::*;
(
    input  logic      bus_ce,
    input  logic      bus_cs_n,
    input  logic      bus_rd_cnv,
    input  logic      fmt_wide,
    input  logic      addr_lo,
    output logic      conv_req,
    output logic      conv_short,
    output logic      rd_req,
    output read_fmt_t rd_fmt
);

    logic selected;

    always_comb begin
        selected   = bus_ce && !bus_cs_n;
        conv_req   = selected && !bus_rd_cnv;
        conv_short = addr_lo;
        rd_req     = selected && bus_rd_cnv;
        if (fmt_wide)
            rd_fmt = RD_WIDE;
        else if (addr_lo)
            rd_fmt = RD_LOW;
        else
            rd_fmt = RD_HIGH;
    end

endmodule

// File: rtl/sar_bit_core.sv
module sar_bit_core #(
    parameter int WIDTH   = 12,
    parameter int SHORT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             short_mode,
    input  logic             cmp_above,
    output logic [WIDTH-1:0] trial_code,
    output logic             last_trial,
    output logic [WIDTH-1:0] result
);

    localparam int IDXW = $clog2(WIDTH);
    localparam logic [IDXW-1:0] TOP_IDX   = IDXW'(WIDTH - 1);
    localparam logic [IDXW-1:0] FULL_STOP = '0;
    localparam logic [IDXW-1:0] SHORT_STOP = IDXW'(WIDTH - SHORT_W);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] work_q;
    logic [IDXW-1:0]  ptr_q;
    logic [WIDTH-1:0] mask;
    logic [WIDTH-1:0] decided;
    logic [IDXW-1:0]  stop_idx;

    always_comb begin
        mask       = ONE << ptr_q;
        trial_code = work_q | mask;
        decided    = cmp_above ? work_q : (work_q | mask);
        stop_idx   = short_mode ? SHORT_STOP : FULL_STOP;
        last_trial = (ptr_q == stop_idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '0;
            ptr_q  <= TOP_IDX;
        end else if (clr) begin
            work_q <= '0;
            ptr_q  <= TOP_IDX;
        end else if (step) begin
            work_q <= decided;
            if (!last_trial)
                ptr_q <= ptr_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            result <= '0;
        else if (step && last_trial)
            result <= decided;
    end

    assert_trial_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ($countones(trial_code ^ work_q) == 1));

    assert_short_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last_trial && short_mode) |=> (result[WIDTH-SHORT_W-1:0] == '0));

    assert_result_only_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && last_trial) |=> $stable(result));

endmodule

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
    parameter int ACQ_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CNTW = (ACQ_CLKS > 1) ? $clog2(ACQ_CLKS) : 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(ACQ_CLKS - 1);

    logic [CNTW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || done)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assert_timer_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH    = 12,
    parameter int SHORT_W  = 8,
    parameter int ACQ_CLKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_ce,
    input  logic             bus_cs_n,
    input  logic             bus_rd_cnv,
    input  logic             fmt_wide,
    input  logic             addr_lo,
    input  logic             cmp_above,
    output logic             hold,
    output logic [WIDTH-1:0] dac_code,
    output logic             busy,
    output logic [WIDTH-1:0] data_out,
    output logic             data_oe
);

    localparam int BYTE_W = SHORT_W;
    localparam int LOW_W  = WIDTH - SHORT_W;

    conv_state_t state_q, state_d;
    logic        short_q;
    logic        conv_req, conv_short, rd_req;
    read_fmt_t   rd_fmt;
    logic        clr, step;
    logic        last_trial, acq_done;
    logic [WIDTH-1:0] trial_code, result;

    sar_bus_decode u_dec (
        .bus_ce     (bus_ce),
        .bus_cs_n   (bus_cs_n),
        .bus_rd_cnv (bus_rd_cnv),
        .fmt_wide   (fmt_wide),
        .addr_lo    (addr_lo),
        .conv_req   (conv_req),
        .conv_short (conv_short),
        .rd_req     (rd_req),
        .rd_fmt     (rd_fmt)
    );

    sar_bit_core #(.WIDTH(WIDTH), .SHORT_W(SHORT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .step       (step),
        .short_mode (short_q),
        .cmp_above  (cmp_above),
        .trial_code (trial_code),
        .last_trial (last_trial),
        .result     (result)
    );

    sar_acq_timer #(.ACQ_CLKS(ACQ_CLKS)) u_acq (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_ACQ),
        .done  (acq_done)
    );

    // State register and conversion length latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            short_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && conv_req)
                short_q <= conv_short;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (conv_req) state_d = ST_HOLD;
            ST_HOLD:  state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_TRIAL;
            ST_TRIAL: if (last_trial) state_d = ST_ACQ;
            ST_ACQ:   if (acq_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        hold     = 1'b0;
        busy     = 1'b1;
        clr      = 1'b0;
        step     = 1'b0;
        dac_code = '0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_HOLD:  hold = 1'b1;
            ST_CLEAR: begin
                hold = 1'b1;
                clr  = 1'b1;
            end
            ST_TRIAL: begin
                hold     = 1'b1;
                step     = 1'b1;
                dac_code = trial_code;
            end
            ST_ACQ:   hold = 1'b0;
            default:  busy = 1'b0;
        endcase

        data_oe  = rd_req && !hold;
        data_out = '0;
        if (data_oe) begin
            unique case (rd_fmt)
                RD_WIDE: data_out = result;
                RD_HIGH: data_out = {{LOW_W{1'b0}}, result[WIDTH-1 -: BYTE_W]};
                RD_LOW:  data_out = {{(WIDTH-BYTE_W){1'b0}}, result[LOW_W-1:0], {(BYTE_W-LOW_W){1'b0}}};
                default: data_out = '0;
            endcase
        end
    end

    assert_start_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(conv_req));

    assert_hold_within_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> busy);

    assert_dac_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (dac_code == '0));

    assert_no_oe_converting_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !data_oe);

    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && state_q != ST_HOLD) |-> $past(hold));

    assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0));

    assert_undecoded_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(bus_ce && !bus_cs_n)) |=> !busy);

endmodule

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;

    localparam int W   = 12;
    localparam int ACQ = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_ce = 1'b0, bus_cs_n = 1'b1, bus_rd_cnv = 1'b1, fmt_wide = 1'b1, addr_lo = 1'b0;
    logic [W-1:0] vin = '0;
    logic cmp_above;
    logic hold, busy, data_oe;
    logic [W-1:0] dac_code, data_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    assign cmp_above = (dac_code > vin);

    sar_conv_ctrl #(.WIDTH(W), .SHORT_W(8), .ACQ_CLKS(ACQ)) uut (
        .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .bus_cs_n(bus_cs_n),
        .bus_rd_cnv(bus_rd_cnv), .fmt_wide(fmt_wide), .addr_lo(addr_lo),
        .cmp_above(cmp_above), .hold(hold), .dac_code(dac_code), .busy(busy),
        .data_out(data_out), .data_oe(data_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_idle();
        bus_ce = 1'b0; bus_cs_n = 1'b1; bus_rd_cnv = 1'b1; fmt_wide = 1'b1; addr_lo = 1'b0;
    endtask

    task automatic bus_read(input logic wide, input logic a0);
        bus_ce = 1'b1; bus_cs_n = 1'b0; bus_rd_cnv = 1'b1; fmt_wide = wide; addr_lo = a0;
    endtask

    // Runs one conversion; optionally fires a restart attempt at trial offset 'poke'
    task automatic convert(input logic short_m, input int poke);
        int n, len, expv, acq_seen;
        logic oe_bad;
        n    = short_m ? 8 : 12;
        expv = short_m ? (int'(vin) & 'hFF0) : int'(vin);
        @(negedge clk);
        bus_ce = 1'b1; bus_cs_n = 1'b0; bus_rd_cnv = 1'b0; addr_lo = short_m;
        @(negedge clk);
        check("R2 busy after start", int'(busy), 1);
        check("R3 hold with busy", int'(hold), 1);
        bus_read(1'b1, 1'b0);
        len = 0; acq_seen = 0; oe_bad = 1'b0;
        while (busy && len < 100) begin
            if (hold && data_oe) oe_bad = 1'b1;
            if (!hold && acq_seen == 0) begin
                acq_seen = 1;
                check("R8 oe during acquisition", int'(data_oe), 1);
                check("R11 acquisition read", int'(data_out), expv);
                check("R6 hold falls after last trial", len, 2 + n);
            end
            len++;
            if (len == poke) begin
                bus_ce = 1'b1; bus_cs_n = 1'b0; bus_rd_cnv = 1'b0; addr_lo = ~short_m;
            end else begin
                bus_read(1'b1, 1'b0);
            end
            @(negedge clk);
        end
        check("R8 no oe while holding", int'(oe_bad), 0);
        check(poke > 0 ? "R7 busy length after restart attempt" : "R6 busy length", len, 2 + n + ACQ);
        bus_read(1'b1, 1'b0);
        #1;
        check(short_m ? "R5 short result" : "R4 full result", int'(data_out), expv);
        bus_read(1'b0, 1'b0);
        #1;
        check("R9 high byte", int'(data_out), expv >> 4);
        bus_read(1'b0, 1'b1);
        #1;
        check("R9 low nibble", int'(data_out), (expv & 'hF) << 4);
        bus_idle();
        #1;
        check("R10 quiet bus", int'({data_oe, data_out}), 0);
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R10 reset oe", int'(data_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 reset hold", int'(hold), 0);
        check("R2 reset busy", int'(busy), 0);
        check("R3 reset dac", int'(dac_code), 0);

        // R1: undecoded commands
        vin = 12'h5A5;
        bus_ce = 1'b0; bus_cs_n = 1'b0; bus_rd_cnv = 1'b0;
        @(negedge clk);
        check("R1 ce low no start", int'(busy), 0);
        bus_ce = 1'b1; bus_cs_n = 1'b1; bus_rd_cnv = 1'b0;
        @(negedge clk);
        check("R1 cs high no start", int'(busy), 0);
        bus_ce = 1'b0; bus_cs_n = 1'b0; bus_rd_cnv = 1'b1;
        #1;
        check("R1 undecoded read oe", int'(data_oe), 0);
        bus_idle();

        // R7: restart attempts mid-trial and in acquisition
        convert(1'b0, 6);
        convert(1'b1, 4);
        vin = 12'h3C7;
        convert(1'b0, 15);

        // Near-exhaustive sweep, R4/R5
        for (int v = 0; v < 4096; v += 17) begin
            vin = W'(v);
            convert(1'b0, 0);
            convert(1'b1, 0);
        end
        vin = 12'hFFF;
        convert(1'b0, 0);
        convert(1'b1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule